// File: doc/BRIEF.md
# LDPC Variable Node Accumulator

This block keeps the per-node state of the variable nodes in an iterative LDPC decoder. Each node's state sits in one word of an external simple dual-port RAM. The word holds three things: an iteration-parity tag, the signed channel LLR, and a running sum of the check-to-variable messages the node has received. There are 2^(7+FOLD) nodes.

Every cycle the block takes one operation and passes it down a fixed six-cycle pipeline. The operation comes from one of two ports:
- The load port writes a channel LLR into a node or reads a node back.
- The message port adds a sign-magnitude check message into a node's sum, or reads the node without changing it.

Updates are read-modify-write through the RAM. Results still in flight are forwarded back into the update, so updates to the same node on consecutive cycles, or at any spacing, accumulate correctly. The sum is cleared lazily: when a message arrives with a parity that differs from the node's stored tag, the old sum counts as zero. The sum saturates at a wide internal limit. Both outputs saturate at the narrow LLR limit.

Top module: `vnode_accum`

## Requirements
- R1: With `ld_access`=1 and `ld_we`=1, the signed `ld_din` is stored at `ld_addr`, the node's sum becomes zero and its tag takes `iter_par`. Reading the node back then returns that LLR.
- R2: For every presented operation, `ld_dout` and `v2c_msg` both carry the saturated value of LLR plus sum for the addressed node, taken after that operation's own update. The value appears exactly 6 cycles after the address is presented.
- R3: A message changes the node only when `msg_we`=1 and `msg_mask`=0. With `msg_mask`=1 the node is unchanged and no RAM write happens. `ld_access`=1 selects the load port over the message port.
- R4: If a node's stored tag differs from `iter_par` when a message is applied, the sum counts as zero before the message is added, and the tag is then set to `iter_par`.
- R5: The stored sum saturates symmetrically at ±(2^(LLR_W+3)−1), which is ±127 for 4-bit LLRs. The value −128 is never written.
- R6: All values are sign-magnitude with the sign in the MSB. Outputs saturate at ±(2^(LLR_W−1)−1). A negative zero on an input counts as zero. An output of zero always has a cleared sign bit.
- R7: Updates to the same node accumulate correctly whether they arrive on consecutive cycles or 2, 3 or more cycles apart, including a message that immediately follows a load.
- R8: The RAM word is {tag (MSB), LLR (LLR_W bits, sign-magnitude), sum (LLR_W+4 bits, two's complement, LSBs)}. `ram_rd_addr` shows the presented address one cycle after presentation. The resulting write appears on `ram_we`/`ram_wr_addr`/`ram_wdata` three cycles after presentation. The RAM has a one-cycle read latency and returns old data on a same-cycle collision.
- R9: Synchronous active-low reset holds `ram_we` low and drives both outputs to zero. RAM contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_access | input | 1 | Load port owns this cycle |
| ld_we | input | 1 | Load port write (with ld_access) |
| ld_addr | input | ADDR_W | Load port node address |
| ld_din | input | LLR_W | Channel LLR, sign-magnitude |
| ld_dout | output | LLR_W | Saturated LLR plus sum, 6 cycles later |
| iter_par | input | 1 | Current iteration parity |
| msg_we | input | 1 | Message write enable |
| msg_mask | input | 1 | Suppress this message |
| msg_addr | input | ADDR_W | Message port node address |
| c2v_msg | input | LLR_W | Check-to-variable message, sign-magnitude |
| v2c_msg | output | LLR_W | Variable-to-check message, 6 cycles later |
| ram_rd_addr | output | ADDR_W | RAM read address |
| ram_wr_addr | output | ADDR_W | RAM write address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 2*LLR_W+5 | RAM write word |
| ram_rdata | input | 2*LLR_W+5 | RAM read word, one cycle after address |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- a load always produces a RAM write with a zero sum three cycles later;
- a masked message never produces a write;
- the read address follows the load address;
- the stored sum never reaches the forbidden minimum;
- the output never shows a negative zero.

Other behaviours show only in the bench's scenarios, which compare every output against an independent model of the node values:
- forwarding between consecutive and closely spaced updates to one node;
- lazy clearing on a parity change;
- the difference between the wide and narrow saturation limits;
- the survival of RAM contents across reset.

// File: rtl/vnode_pkg.sv
// Shared types of the variable node accumulator.
package vnode_pkg;
    // Operation carried down the pipeline
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_READ = 2'd1,
        OP_LOAD = 2'd2,
        OP_MSG  = 2'd3
    } op_e;
endpackage

// File: rtl/vnode_issue.sv
// vnode_issue: picks one operation per cycle from the load port or the
// message port and registers it as pipeline stage 1.
// Assumes: the load port has priority whenever ld_access is high.
module vnode_issue
    import vnode_pkg::*;
#(
    parameter int LLR_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_access,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LLR_W-1:0]  ld_din,
    input  logic              iter_par,
    input  logic              msg_we,
    input  logic              msg_mask,
    input  logic [ADDR_W-1:0] msg_addr,
    input  logic [LLR_W-1:0]  c2v_msg,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LLR_W-1:0]  s1_din,
    output logic              s1_iter
);
    op_e               dec_op;
    logic [ADDR_W-1:0] dec_addr;
    logic [LLR_W-1:0]  dec_din;

    // Decode which port owns the cycle and what it asks for
    always_comb begin
        if (ld_access) begin
            dec_op   = ld_we ? OP_LOAD : OP_READ;
            dec_addr = ld_addr;
            dec_din  = ld_din;
        end else begin
            dec_op   = (msg_we && !msg_mask) ? OP_MSG : OP_READ;
            dec_addr = msg_addr;
            dec_din  = c2v_msg;
        end
    end

    // Stage 1 register; the address also drives the RAM read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op <= OP_NONE;
        end else begin
            s1_op <= dec_op;
        end
        s1_addr <= dec_addr;
        s1_din  <= dec_din;
        s1_iter <= iter_par;
    end
endmodule

// File: rtl/vnode_update.sv
// vnode_update: merges the RAM word with in-flight writes, applies the
// operation (load, message accumulate or plain read) and issues the write.
// Assumes: the RAM has one-cycle read latency and returns old data when a
// read and a write hit the same address in one cycle.
module vnode_update
    import vnode_pkg::*;
#(
    parameter int LLR_W  = 4,
    parameter int ADDR_W = 8,
    parameter int SUM_W  = LLR_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               s1_op,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [LLR_W-1:0]  s1_din,
    input  logic              s1_iter,
    input  logic [1+LLR_W+SUM_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_wr_addr,
    output logic [1+LLR_W+SUM_W-1:0] ram_wdata,
    output logic              s3_vld,
    output logic [1+LLR_W+SUM_W-1:0] s3_word
);
    localparam int WORD_W = 1 + LLR_W + SUM_W;
    localparam int CALC_W = SUM_W + 1;
    localparam logic signed [CALC_W-1:0] SUM_HI = CALC_W'((2 ** (SUM_W - 1)) - 1);
    localparam logic signed [CALC_W-1:0] SUM_LO = -SUM_HI;

    // Sign-magnitude to two's complement, negative zero becomes zero
    function automatic logic signed [CALC_W-1:0] sm_to_s(input logic [LLR_W-1:0] x);
        logic signed [CALC_W-1:0] m;
        m = signed'({{(CALC_W - LLR_W + 1){1'b0}}, x[LLR_W-2:0]});
        return x[LLR_W-1] ? -m : m;
    endfunction

    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [LLR_W-1:0]  s2_din;
    logic              s2_iter;
    logic              s3_we;
    logic [ADDR_W-1:0] s3_addr;
    logic              s4_we;
    logic [ADDR_W-1:0] s4_addr;
    logic [WORD_W-1:0] s4_word;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] nxt_word;
    logic              nxt_we;
    logic signed [CALC_W-1:0] prev_sum;
    logic signed [CALC_W-1:0] acc;
    logic signed [CALC_W-1:0] acc_sat;

    // Stage 2 register, aligned with the RAM read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op <= OP_NONE;
        end else begin
            s2_op <= s1_op;
        end
        s2_addr <= s1_addr;
        s2_din  <= s1_din;
        s2_iter <= s1_iter;
    end

    // Forward the newest in-flight write to the same node over the RAM data
    always_comb begin
        if (s3_we && (s3_addr == s2_addr)) begin
            base = s3_word;
        end else if (s4_we && (s4_addr == s2_addr)) begin
            base = s4_word;
        end else begin
            base = ram_rdata;
        end
    end

    // Lazily cleared, saturating accumulation of one message
    always_comb begin
        prev_sum = (base[WORD_W-1] == s2_iter)
                 ? signed'({base[SUM_W-1], base[SUM_W-1:0]}) : '0;
        acc      = prev_sum + sm_to_s(s2_din);
        if (acc > SUM_HI) begin
            acc_sat = SUM_HI;
        end else if (acc < SUM_LO) begin
            acc_sat = SUM_LO;
        end else begin
            acc_sat = acc;
        end
    end

    // Build the next node word and decide whether it is written back
    always_comb begin
        unique case (s2_op)
            OP_LOAD: begin
                nxt_word = {s2_iter, s2_din, {SUM_W{1'b0}}};
                nxt_we   = 1'b1;
            end
            OP_MSG: begin
                nxt_word = {s2_iter, base[SUM_W +: LLR_W], acc_sat[SUM_W-1:0]};
                nxt_we   = 1'b1;
            end
            default: begin
                nxt_word = base;
                nxt_we   = 1'b0;
            end
        endcase
    end

    // Stage 3 register: holds the write to the RAM and feeds the output path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_we  <= 1'b0;
            s3_vld <= 1'b0;
        end else begin
            s3_we  <= nxt_we;
            s3_vld <= (s2_op != OP_NONE);
        end
        s3_addr <= s2_addr;
        s3_word <= nxt_word;
    end

    // Stage 4 copy of the last write, covering the RAM's read-old window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s4_we <= 1'b0;
        end else begin
            s4_we <= s3_we;
        end
        s4_addr <= s3_addr;
        s4_word <= s3_word;
    end

    assign ram_we      = s3_we;
    assign ram_wr_addr = s3_addr;
    assign ram_wdata   = s3_word;

    // R5
    sum_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_wdata[SUM_W-1:0] != {1'b1, {(SUM_W-1){1'b0}}}));
endmodule

// File: rtl/vnode_emit.sv
// vnode_emit: turns a node word into the saturated sign-magnitude output
// (LLR plus sum) and delays it so that it leaves the block on the sixth cycle.
// Assumes: the word arrives at pipeline stage 3.
module vnode_emit #(
    parameter int LLR_W = 4,
    parameter int SUM_W = LLR_W + 4,
    parameter int DLY   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s3_vld,
    input  logic [1+LLR_W+SUM_W-1:0] s3_word,
    output logic [LLR_W-1:0]         res
);
    localparam int CALC_W = SUM_W + 2;
    localparam logic signed [CALC_W-1:0] OUT_HI = CALC_W'((2 ** (LLR_W - 1)) - 1);
    localparam logic signed [CALC_W-1:0] OUT_LO = -OUT_HI;

    logic signed [CALC_W-1:0] llr_s;
    logic signed [CALC_W-1:0] tot;
    logic signed [CALC_W-1:0] tot_sat;
    logic signed [CALC_W-1:0] neg;
    logic [LLR_W-1:0]         sm_val;
    logic [LLR_W-1:0]         pipe [DLY];

    // Add LLR and sum, clamp to the LLR range, encode as sign-magnitude
    always_comb begin
        llr_s = signed'({{(CALC_W - LLR_W + 1){1'b0}}, s3_word[SUM_W +: LLR_W-1]});
        if (s3_word[SUM_W+LLR_W-1]) begin
            llr_s = -llr_s;
        end
        tot = llr_s + signed'({{2{s3_word[SUM_W-1]}}, s3_word[SUM_W-1:0]});
        if (tot > OUT_HI) begin
            tot_sat = OUT_HI;
        end else if (tot < OUT_LO) begin
            tot_sat = OUT_LO;
        end else begin
            tot_sat = tot;
        end
        neg = -tot_sat;
        if (tot_sat < 0) begin
            sm_val = {1'b1, neg[LLR_W-2:0]};
        end else begin
            sm_val = {1'b0, tot_sat[LLR_W-2:0]};
        end
    end

    // First output stage captures the encoded value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe[0] <= '0;
        end else begin
            pipe[0] <= s3_vld ? sm_val : '0;
        end
    end

    // Remaining delay stages
    for (genvar g = 1; g < DLY; g++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe[g] <= '0;
            end else begin
                pipe[g] <= pipe[g-1];
            end
        end
    end

    assign res = pipe[DLY-1];

    // R6
    out_no_negzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res[LLR_W-1] |-> (res[LLR_W-2:0] != '0));
endmodule

// File: rtl/vnode_ram.sv
// vnode_ram: behavioural simple dual-port RAM for test.
// One-cycle registered read; a same-cycle read of a written address gets old data.
module vnode_ram #(
    parameter int WIDTH  = 13,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  din,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  dout
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    // Write port and registered read port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_addr] <= din;
        end
        dout <= mem[rd_addr];
    end
endmodule

// File: rtl/vnode_accum.sv
// vnode_accum: variable node accumulator top. Operations enter through the
// load or message port, read-modify-write node words in an external RAM, and
// produce saturated LLR-plus-sum results six cycles later on both outputs.
// Assumes: the RAM behaves like vnode_ram (one-cycle read, read-old collision).
module vnode_accum
    import vnode_pkg::*;
#(
    parameter int LLR_W = 4,
    parameter int FOLD  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_access,
    input  logic                     ld_we,
    input  logic [7+FOLD-1:0]        ld_addr,
    input  logic [LLR_W-1:0]         ld_din,
    output logic [LLR_W-1:0]         ld_dout,
    input  logic                     iter_par,
    input  logic                     msg_we,
    input  logic                     msg_mask,
    input  logic [7+FOLD-1:0]        msg_addr,
    input  logic [LLR_W-1:0]         c2v_msg,
    output logic [LLR_W-1:0]         v2c_msg,
    output logic [7+FOLD-1:0]        ram_rd_addr,
    output logic [7+FOLD-1:0]        ram_wr_addr,
    output logic                     ram_we,
    output logic [2*LLR_W+4:0]       ram_wdata,
    input  logic [2*LLR_W+4:0]       ram_rdata
);
    localparam int ADDR_W = 7 + FOLD;
    localparam int SUM_W  = LLR_W + 4;
    localparam int WORD_W = 1 + LLR_W + SUM_W;

    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LLR_W-1:0]  s1_din;
    logic              s1_iter;
    logic              s3_vld;
    logic [WORD_W-1:0] s3_word;
    logic [LLR_W-1:0]  res;

    vnode_issue #(.LLR_W(LLR_W), .ADDR_W(ADDR_W)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .ld_access(ld_access), .ld_we(ld_we), .ld_addr(ld_addr), .ld_din(ld_din),
        .iter_par(iter_par), .msg_we(msg_we), .msg_mask(msg_mask),
        .msg_addr(msg_addr), .c2v_msg(c2v_msg),
        .s1_op(s1_op), .s1_addr(s1_addr), .s1_din(s1_din), .s1_iter(s1_iter)
    );

    vnode_update #(.LLR_W(LLR_W), .ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_update (
        .clk(clk), .rst_n(rst_n),
        .s1_op(s1_op), .s1_addr(s1_addr), .s1_din(s1_din), .s1_iter(s1_iter),
        .ram_rdata(ram_rdata),
        .ram_we(ram_we), .ram_wr_addr(ram_wr_addr), .ram_wdata(ram_wdata),
        .s3_vld(s3_vld), .s3_word(s3_word)
    );

    vnode_emit #(.LLR_W(LLR_W), .SUM_W(SUM_W), .DLY(3)) u_emit (
        .clk(clk), .rst_n(rst_n),
        .s3_vld(s3_vld), .s3_word(s3_word), .res(res)
    );

    assign ram_rd_addr = s1_addr;
    assign ld_dout     = res;
    assign v2c_msg     = res;

    // Cycles since reset, saturating; lets history-based checks start safely
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    // R1
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(ld_access && ld_we, 3)) |->
            (ram_we && ram_wr_addr == $past(ld_addr, 3)
                    && ram_wdata[SUM_W-1:0] == '0));

    // R3
    masked_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(!ld_access && msg_we && msg_mask, 3)) |-> !ram_we);

    // R8
    rd_addr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && $past(ld_access)) |-> (ram_rd_addr == $past(ld_addr)));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ram_we && ld_dout == '0));
endmodule

// File: tb/vnode_accum_bench.sv
module vnode_accum_bench;
    localparam int LLR_W = 4;
    localparam int AW    = 8;
    localparam int WW    = 2 * LLR_W + 5;
    localparam int LAT   = 6;

    // op: 0 read via load port, 1 load, 2 message, 3 masked message, 4 read via message port
    typedef struct packed {
        logic [2:0] op;
        logic [7:0] addr;
        logic [3:0] val;
        logic       it;
        logic [5:0] rep;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 8'd5,   4'b0011, 1'b0, 6'd1},   // R1 load +3
        '{3'd1, 8'd9,   4'b1110, 1'b0, 6'd1},   // R1 load -6
        '{3'd1, 8'd200, 4'b1000, 1'b0, 6'd1},   // R6 load negative zero
        '{3'd1, 8'd255, 4'b1111, 1'b0, 6'd1},   // R1 load -7
        '{3'd1, 8'd0,   4'b0001, 1'b0, 6'd1},   // R1 load +1
        '{3'd0, 8'd5,   4'b0000, 1'b0, 6'd1},   // R2 readback
        '{3'd4, 8'd9,   4'b0000, 1'b0, 6'd1},   // R2 read via message port
        '{3'd0, 8'd200, 4'b0000, 1'b0, 6'd1},   // R6 zero with cleared sign
        '{3'd2, 8'd5,   4'b0010, 1'b0, 6'd1},   // R2 message +2
        '{3'd2, 8'd5,   4'b0011, 1'b0, 6'd1},   // R7 back-to-back, R6 output clamp
        '{3'd2, 8'd5,   4'b1100, 1'b0, 6'd1},   // R7 third in a row
        '{3'd3, 8'd5,   4'b0111, 1'b0, 6'd1},   // R3 masked message
        '{3'd4, 8'd5,   4'b0000, 1'b0, 6'd1},   // R3 unchanged
        '{3'd2, 8'd9,   4'b0010, 1'b0, 6'd1},   // R7 spaced updates start
        '{3'd0, 8'd0,   4'b0000, 1'b0, 6'd1},
        '{3'd2, 8'd9,   4'b0001, 1'b0, 6'd1},   // R7 gap of two
        '{3'd0, 8'd0,   4'b0000, 1'b0, 6'd2},
        '{3'd2, 8'd9,   4'b0001, 1'b0, 6'd1},   // R7 gap of three
        '{3'd2, 8'd5,   4'b1001, 1'b1, 6'd1},   // R4 parity flip clears sum
        '{3'd2, 8'd5,   4'b1001, 1'b1, 6'd1},   // R4 same parity accumulates
        '{3'd1, 8'd0,   4'b0010, 1'b1, 6'd1},   // R1 reload
        '{3'd2, 8'd0,   4'b0011, 1'b1, 6'd1},   // R7 message right after load
        '{3'd2, 8'd255, 4'b0111, 1'b1, 6'd19},  // R5 drive sum past +127
        '{3'd2, 8'd255, 4'b1111, 1'b1, 6'd18},  // R5 clamp visible on the way down
        '{3'd2, 8'd200, 4'b1000, 1'b0, 6'd1},   // R6 negative zero message
        '{3'd0, 8'd200, 4'b0000, 1'b0, 6'd1},   // R6
        '{3'd4, 8'd255, 4'b0000, 1'b0, 6'd1},   // R5
        '{3'd0, 8'd9,   4'b0000, 1'b0, 6'd6}    // drain
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_access = 1'b0, ld_we = 1'b0, iter_par = 1'b0;
    logic msg_we = 1'b0, msg_mask = 1'b0;
    logic [AW-1:0] ld_addr = '0, msg_addr = '0;
    logic [LLR_W-1:0] ld_din = '0, c2v_msg = '0;
    logic [LLR_W-1:0] ld_dout, v2c_msg;
    logic [AW-1:0] ram_rd_addr, ram_wr_addr;
    logic ram_we;
    logic [WW-1:0] ram_wdata, ram_rdata;

    always #5 clk = ~clk;

    vnode_accum u_vnode_accum (
        .clk(clk), .rst_n(rst_n),
        .ld_access(ld_access), .ld_we(ld_we), .ld_addr(ld_addr), .ld_din(ld_din),
        .ld_dout(ld_dout), .iter_par(iter_par), .msg_we(msg_we), .msg_mask(msg_mask),
        .msg_addr(msg_addr), .c2v_msg(c2v_msg), .v2c_msg(v2c_msg),
        .ram_rd_addr(ram_rd_addr), .ram_wr_addr(ram_wr_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    vnode_ram #(.WIDTH(WW), .ADDR_W(AW)) u_ram (
        .clk(clk), .we(ram_we), .wr_addr(ram_wr_addr), .din(ram_wdata),
        .rd_addr(ram_rd_addr), .dout(ram_rdata)
    );

    int errors = 0;
    int checks = 0;
    int m_llr [256];
    int m_sum [256];
    bit m_tag [256];
    logic [LLR_W-1:0] exq [8];
    bit evq [8];
    int cnt = 0;

    function automatic int sm2i(logic [3:0] x);
        return x[3] ? -int'(x[2:0]) : int'(x[2:0]);
    endfunction

    function automatic int clampi(int v, int lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    function automatic logic [3:0] i2sm(int v);
        logic [3:0] r;
        if (v < 0) r = {1'b1, 3'(-v)};
        else       r = {1'b0, 3'(v)};
        return r;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation per cycle; compares outputs of the op from LAT cycles ago
    task automatic step(logic [2:0] op, logic [7:0] a, logic [3:0] v, logic it);
        int k;
        @(negedge clk);
        if (cnt >= LAT && evq[(cnt - LAT) % 8]) begin
            check("R2 ld_dout", 16'(ld_dout), 16'(exq[(cnt - LAT) % 8]));
            check("R2 v2c_msg", 16'(v2c_msg), 16'(exq[(cnt - LAT) % 8]));
        end
        ld_access = (op <= 3'd1);
        ld_we     = (op == 3'd1);
        ld_addr   = a;
        ld_din    = v;
        msg_we    = (op == 3'd2 || op == 3'd3);
        msg_mask  = (op == 3'd3);
        msg_addr  = a;
        c2v_msg   = v;
        iter_par  = it;
        k = int'(a);
        if (op == 3'd1) begin
            m_llr[k] = sm2i(v); m_sum[k] = 0; m_tag[k] = it;
        end else if (op == 3'd2) begin
            if (m_tag[k] != it) m_sum[k] = 0;
            m_sum[k] = clampi(m_sum[k] + sm2i(v), 127);
            m_tag[k] = it;
        end
        exq[cnt % 8] = i2sm(clampi(m_llr[k] + m_sum[k], 7));
        evq[cnt % 8] = 1'b1;
        cnt++;
    endtask

    task automatic idle();
        ld_access = 1'b0; ld_we = 1'b0; msg_we = 1'b0; msg_mask = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 ram_we in reset", 16'(ram_we), 16'd0);
        check("R9 ld_dout in reset", 16'(ld_dout), 16'd0);
        check("R9 v2c_msg in reset", 16'(v2c_msg), 16'd0);
        rst_n = 1'b1;

        // Vector table walk (R1..R7)
        for (int i = 0; i < NV; i++) begin
            for (int r = 0; r < int'(VEC[i].rep); r++) begin
                step(VEC[i].op, VEC[i].addr, VEC[i].val, VEC[i].it);
            end
        end

        // R8: RAM port timing and word layout for a load of -5, parity 1
        @(negedge clk);
        ld_access = 1'b1; ld_we = 1'b1; ld_addr = 8'd77; ld_din = 4'b1101; iter_par = 1'b1;
        @(negedge clk);
        check("R8 rd_addr", 16'(ram_rd_addr), 16'd77);
        ld_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 ram_we", 16'(ram_we), 16'd1);
        check("R8 wr_addr", 16'(ram_wr_addr), 16'd77);
        check("R8 wdata", 16'(ram_wdata), 16'({1'b1, 4'b1101, 8'h00}));
        repeat (3) @(negedge clk);
        check("R1 readback -5", 16'(ld_dout), 16'(4'b1101));
        m_llr[77] = -5; m_sum[77] = 0; m_tag[77] = 1'b1;

        // R3: disabled message produces no write three cycles later
        ld_access = 1'b0; msg_we = 1'b1; msg_mask = 1'b1; msg_addr = 8'd77; c2v_msg = 4'b0111;
        @(negedge clk);
        idle();
        @(negedge clk);
        @(negedge clk);
        check("R3 no write", 16'(ram_we), 16'd0);

        // R9: mid-run reset, then contents survive
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 ram_we", 16'(ram_we), 16'd0);
        check("R9 v2c_msg", 16'(v2c_msg), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cnt = 0;
        for (int i = 0; i < 8; i++) evq[i] = 1'b0;
        step(3'd0, 8'd77, 4'd0, 1'b1);   // R9 RAM kept across reset
        step(3'd4, 8'd255, 4'd0, 1'b1);  // R5
        for (int i = 0; i < LAT + 1; i++) step(3'd0, 8'd5, 4'd0, 1'b1);
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule